// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees an I2C bus whose data line is held low by a target that lost track of a transfer. It takes direct control of both bus lines through open-drain enables and does not use the normal byte engine. After a start request it first watches SDA for one phase interval. If SDA is already high, the bus is not stuck and the block reports success at once, without touching SCL. If SDA stays low for that whole interval, the block leaves SDA released and clocks SCL nine times. This lets a stuck target shift out the rest of its byte and let go of the line. It then drives a stop condition step by step and checks whether SDA has come free.

The timebase is a strobe input (`tick_i`). Every SCL high phase, SCL low phase and stop step lasts a fixed number of these strobes, set by a parameter. With a 50 MHz clock, one strobe per cycle and a count of 250, each phase is 5 µs. A phase in which SCL is released does not advance while the SCL wire still reads low, so a target that stretches the clock is respected. The status outputs stay valid until the next start request. A start request made while a sequence is running has no effect.

Top module: `i2c_bus_recovery`

## Requirements
- R1: After reset, and whenever `busy_o` is low, both enables are 0, meaning both lines are released. Reset clears `done_o` and `fail_o`. An enable of 1 pulls its line low and 0 releases it.
- R2: If `sda_i` reads 1 during the first phase interval after a start, the block sets `done_o`=1 and `fail_o`=0 and drives no SCL pulse and no SDA low.
- R3: If `sda_i` stays 0 for that whole interval, the block produces exactly `PULSES` (default 9) SCL high-then-low pulses, with `sda_oe_o`=0 throughout.
- R4: Every SCL phase and every stop step lasts `TICKS_PER_PHASE` strobes of `tick_i`, as long as SCL is not being stretched.
- R5: After the last pulse, the stop is driven as four steps of one interval each: SDA released with SCL low; SDA low with SCL low; SDA low with SCL released; both released. SDA is pulled low only while SCL is held low, and is released only while SCL is released.
- R6: At the end of the last stop step the block sets `done_o`=1 and samples `sda_i`. It sets `fail_o`=1 if `sda_i` is 0 and `fail_o`=0 if it is 1.
- R7: A start request while `busy_o`=1 is ignored. The sequence in progress keeps its pulse count and its timing.
- R8: `done_o` and `fail_o` hold their values until the next start request. A start request clears `done_o` on the following clock edge.
- R9: In a phase where SCL is released, the phase timer does not advance while `scl_i` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request pulse |
| tick_i | input | 1 | Timebase strobe, counted per phase |
| sda_i | input | 1 | Sampled SDA wire level |
| scl_i | input | 1 | Sampled SCL wire level |
| scl_oe_o | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence finished, status valid |
| fail_o | output | 1 | SDA still low at the end |

## Verification
The bench models a target that holds SDA low until it has seen a set number of SCL falling edges. It runs recovery against targets that release after 0, 1, 4, 9, 10 and 15 edges. Zero edges separates the early-exit path from the full sequence. Releases at 1, 4 and 9 edges all need the full nine pulses and all end in success. Releases at 10 or more edges still hold SDA at the final sample, which is how pass is told apart from fail. Further directed runs check the following: the bench stretches one SCL high phase, sends a start request in the middle of a run, and checks that status holds and then clears on the next start.

// File: rtl/i2c_recovery_pkg.sv
package i2c_recovery_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PROBE,
        ST_CLK_HI,
        ST_CLK_LO,
        ST_STOP_A,
        ST_STOP_B,
        ST_STOP_C,
        ST_STOP_D,
        ST_DONE
    } rec_state_e;

    typedef struct packed {
        logic scl_low;
        logic sda_low;
    } line_drive_t;

    function automatic line_drive_t drive_of(rec_state_e s);
        line_drive_t d;
        d = '{scl_low: 1'b0, sda_low: 1'b0};
        case (s)
            ST_CLK_LO, ST_STOP_A: d.scl_low = 1'b1;
            ST_STOP_B: begin
                d.scl_low = 1'b1;
                d.sda_low = 1'b1;
            end
            ST_STOP_C: d.sda_low = 1'b1;
            default: d = '{scl_low: 1'b0, sda_low: 1'b0};
        endcase
        return d;
    endfunction

    function automatic logic is_active(rec_state_e s);
        return (s != ST_IDLE) && (s != ST_DONE);
    endfunction

    function automatic logic scl_released(rec_state_e s);
        line_drive_t d;
        d = drive_of(s);
        return !d.scl_low;
    endfunction

endpackage

// File: rtl/rcv_phase_timer.sv
module rcv_phase_timer #(
    parameter int unsigned TICKS_PER_PHASE = 250
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic run,
    input  logic tick,
    input  logic hold,
    output logic expire
);
    localparam int unsigned CW = (TICKS_PER_PHASE > 1) ? $clog2(TICKS_PER_PHASE) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS_PER_PHASE - 1);

    logic [CW-1:0] cnt;
    logic          advance;

    assign advance = run && tick && !hold && !clear;
    assign expire  = advance && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (advance) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    // R4: the count never leaves the phase window
    a_r4_count_in_window: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

    // R9: while held the count does not move
    a_r9_hold_freezes: assert property (@(posedge clk) disable iff (rst)
        (hold && !clear) |=> $stable(cnt));

endmodule

// File: rtl/rcv_seq_ctrl.sv
module rcv_seq_ctrl
    import i2c_recovery_pkg::*;
#(
    parameter int unsigned PULSES = 9
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       expire,
    input  logic       sda_in,
    output rec_state_e state,
    output logic       timer_clear,
    output logic       done,
    output logic       fail
);
    localparam int unsigned PW = (PULSES > 1) ? $clog2(PULSES) : 1;
    localparam logic [PW-1:0] LASTP = PW'(PULSES - 1);

    rec_state_e    nxt;
    logic [PW-1:0] pulse_cnt, pulse_nxt;
    logic          clr_status, set_done, fail_val;

    always_comb begin
        nxt         = state;
        pulse_nxt   = pulse_cnt;
        timer_clear = 1'b0;
        clr_status  = 1'b0;
        set_done    = 1'b0;
        fail_val    = 1'b0;
        case (state)
            ST_IDLE, ST_DONE: begin
                if (start) begin
                    nxt         = ST_PROBE;
                    timer_clear = 1'b1;
                    clr_status  = 1'b1;
                end
            end
            ST_PROBE: begin
                if (sda_in) begin
                    nxt      = ST_DONE;
                    set_done = 1'b1;
                end else if (expire) begin
                    nxt       = ST_CLK_HI;
                    pulse_nxt = '0;
                end
            end
            ST_CLK_HI: if (expire) nxt = ST_CLK_LO;
            ST_CLK_LO: begin
                if (expire) begin
                    if (pulse_cnt == LASTP) begin
                        nxt = ST_STOP_A;
                    end else begin
                        nxt       = ST_CLK_HI;
                        pulse_nxt = pulse_cnt + 1'b1;
                    end
                end
            end
            ST_STOP_A: if (expire) nxt = ST_STOP_B;
            ST_STOP_B: if (expire) nxt = ST_STOP_C;
            ST_STOP_C: if (expire) nxt = ST_STOP_D;
            ST_STOP_D: begin
                if (expire) begin
                    nxt      = ST_DONE;
                    set_done = 1'b1;
                    fail_val = !sda_in;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            pulse_cnt <= '0;
            done      <= 1'b0;
            fail      <= 1'b0;
        end else begin
            state     <= nxt;
            pulse_cnt <= pulse_nxt;
            if (clr_status) begin
                done <= 1'b0;
                fail <= 1'b0;
            end else if (set_done) begin
                done <= 1'b1;
                fail <= fail_val;
            end
        end
    end

    // R3: pulse index never exceeds the configured pulse count
    a_r3_pulse_bound: assert property (@(posedge clk) disable iff (rst)
        pulse_cnt <= LASTP);

    // R3: the stop is only entered from the low phase of the final pulse
    a_r3_stop_after_last: assert property (@(posedge clk) disable iff (rst)
        (state == ST_STOP_A && $past(state) != ST_STOP_A) |-> $past(pulse_cnt) == LASTP);

    // R7: once running, a start request does not send the sequence back to the probe
    a_r7_no_restart: assert property (@(posedge clk) disable iff (rst)
        (is_active(state) && state != ST_PROBE) |=> state != ST_PROBE);

endmodule

// File: rtl/i2c_bus_recovery.sv
module i2c_bus_recovery
    import i2c_recovery_pkg::*;
#(
    parameter int unsigned TICKS_PER_PHASE = 250,
    parameter int unsigned PULSES          = 9
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic tick_i,
    input  logic sda_i,
    input  logic scl_i,
    output logic scl_oe_o,
    output logic sda_oe_o,
    output logic busy_o,
    output logic done_o,
    output logic fail_o
);
    rec_state_e  state;
    line_drive_t drv;
    logic        timer_clear, expire, hold, run;

    assign run    = is_active(state);
    assign hold   = scl_released(state) && !scl_i;
    assign drv    = drive_of(state);
    assign busy_o = run;
    assign scl_oe_o = drv.scl_low;
    assign sda_oe_o = drv.sda_low;

    rcv_phase_timer #(
        .TICKS_PER_PHASE(TICKS_PER_PHASE)
    ) u_timer (
        .clk   (clk),
        .rst   (rst),
        .clear (timer_clear),
        .run   (run),
        .tick  (tick_i),
        .hold  (hold),
        .expire(expire)
    );

    rcv_seq_ctrl #(
        .PULSES(PULSES)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start_i),
        .expire     (expire),
        .sda_in     (sda_i),
        .state      (state),
        .timer_clear(timer_clear),
        .done       (done_o),
        .fail       (fail_o)
    );

    // R1: outside a sequence both lines are released
    a_r1_idle_released: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (!scl_oe_o && !sda_oe_o));

    // R5: SDA is pulled low only under a held-low SCL
    a_r5_sda_low_under_scl_low: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe_o) |-> (scl_oe_o && $past(scl_oe_o)));

    // R5: SDA release forms a stop, with SCL released
    a_r5_stop_edge: assert property (@(posedge clk) disable iff (rst)
        $fell(sda_oe_o) |-> !scl_oe_o);

    // R6: failure is only reported together with completion
    a_r6_fail_needs_done: assert property (@(posedge clk) disable iff (rst)
        fail_o |-> done_o);

    // R8: status holds until a start request arrives
    a_r8_status_hold: assert property (@(posedge clk) disable iff (rst)
        (done_o && !start_i) |=> (done_o && $stable(fail_o)));

    // R9: a stretched SCL freezes the drive pattern
    a_r9_stretch_freeze: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !scl_oe_o && !scl_i && state != ST_PROBE) |=> ($stable(scl_oe_o) && $stable(sda_oe_o)));

endmodule

// File: tb/sim_i2c_bus_recovery.sv
module sim_i2c_bus_recovery;
    localparam int TPP       = 3;
    localparam int PHASE_CYC = 6;   // 3 ticks, one tick every 2 cycles
    localparam int NVEC      = 6;
    // {release after N falls [3:0], expected pulses [3:0], expected fail}
    localparam logic [8:0] VEC [NVEC] = '{
        {4'd0,  4'd0, 1'b0},
        {4'd1,  4'd9, 1'b0},
        {4'd4,  4'd9, 1'b0},
        {4'd9,  4'd9, 1'b0},
        {4'd10, 4'd9, 1'b1},
        {4'd15, 4'd9, 1'b1}
    };

    logic clk = 1'b0, rst = 1'b1, start_i = 1'b0, tick_i = 1'b0;
    logic scl_oe_o, sda_oe_o, busy_o, done_o, fail_o;
    logic sda_i, scl_i;
    logic stretch = 1'b0, mon_clr = 1'b0, stretch_arm = 1'b0;
    int   tgt_n = 0, tgt_falls = 0;
    int   falls_pre, rises, sfalls, bad, lo_run, lo_count, first_lo, hi_run, hi_idx, hi4, st_cnt;
    bit   prev_scl, prev_sda_oe, prev_scl_oe, sda_seen;
    int   checks = 0, errors = 0, cyc = 0;

    always #10 clk = ~clk;

    assign scl_i = !scl_oe_o && !stretch;
    assign sda_i = !sda_oe_o && !(tgt_falls < tgt_n);

    i2c_bus_recovery #(.TICKS_PER_PHASE(TPP), .PULSES(9)) u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .tick_i(tick_i),
        .sda_i(sda_i), .scl_i(scl_i), .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o),
        .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o));

    always @(negedge clk) tick_i <= rst ? 1'b0 : ~tick_i;

    always @(negedge clk) begin
        if (mon_clr) begin
            tgt_falls = 0; falls_pre = 0; rises = 0; sfalls = 0; bad = 0;
            lo_run = 0; lo_count = 0; first_lo = 0; hi_run = 0; hi_idx = 0; hi4 = 0;
            st_cnt = 0; stretch = 1'b0; sda_seen = 1'b0;
            prev_scl = 1'b1; prev_sda_oe = 1'b0; prev_scl_oe = 1'b0;
        end else begin
            if (prev_scl && !(!scl_oe_o && !stretch)) begin
                tgt_falls++;
                if (!sda_seen) falls_pre++;
            end
            if (sda_oe_o && !prev_sda_oe) begin
                rises++; sda_seen = 1'b1;
                if (!scl_oe_o) bad++;
            end
            if (!sda_oe_o && prev_sda_oe) begin
                sfalls++;
                if (scl_oe_o) bad++;
            end
            if (scl_oe_o) lo_run++;
            if (!scl_oe_o && prev_scl_oe) begin
                lo_count++;
                if (lo_count == 1) first_lo = lo_run;
                lo_run = 0;
            end
            if (!scl_oe_o && busy_o) hi_run++;
            if (st_cnt > 0) begin
                st_cnt--;
                if (st_cnt == 0) stretch = 1'b0;
            end
            if (scl_oe_o && !prev_scl_oe) begin
                hi_idx++;
                if (hi_idx == 4) hi4 = hi_run;
                hi_run = 0;
                if (hi_idx == 3 && stretch_arm) begin
                    stretch = 1'b1; st_cnt = 14;
                end
            end
            prev_scl    = !scl_oe_o && !stretch;
            prev_sda_oe = sda_oe_o;
            prev_scl_oe = scl_oe_o;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_done(input bit mid_start);
        for (int c = 0; c < 3000; c++) begin
            @(negedge clk); #2;
            start_i = (mid_start && c == 40);
            if (done_o) break;
        end
        start_i = 1'b0;
    endtask

    task automatic run_rec(input int n, input bit mid_start);
        @(negedge clk); #2 tgt_n = n; mon_clr = 1'b1;
        @(negedge clk); #2 mon_clr = 1'b0; start_i = 1'b1;
        @(negedge clk); #2 start_i = 1'b0;
        wait_done(mid_start);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        mon_clr = 1'b1;
        repeat (4) @(negedge clk);
        #2 rst = 1'b0;
        @(negedge clk); #1;
        // R1 reset state
        chk("R1 scl_oe after reset", scl_oe_o, 0);
        chk("R1 sda_oe after reset", sda_oe_o, 0);
        chk("R1 busy after reset", busy_o, 0);
        chk("R1 done after reset", done_o, 0);
        chk("R1 fail after reset", fail_o, 0);

        for (int v = 0; v < NVEC; v++) begin
            run_rec(int'(VEC[v][8:5]), 1'b0);
            #1;
            chk("R6 done at end", done_o, 1);
            chk("R6 fail result", fail_o, int'(VEC[v][0]));
            chk("R3 pulse count (R2 when zero)", falls_pre, int'(VEC[v][4:1]));
            if (VEC[v][4:1] == 4'd0) begin
                chk("R2 no SDA drive on early exit", rises, 0);
            end else begin
                chk("R5 one SDA low under SCL low", rises, 1);
                chk("R5 one SDA release under SCL high", sfalls, 1);
                chk("R5 stop edge ordering", bad, 0);
                chk("R4 low phase length", first_lo, PHASE_CYC);
            end
            chk("R1 lines released after run", scl_oe_o | sda_oe_o, 0);
        end

        // R8 status holds
        repeat (20) @(negedge clk);
        #1;
        chk("R8 done held", done_o, 1);
        chk("R8 fail held", fail_o, 1);
        // R8 next start clears done
        #1 start_i = 1'b1;
        @(negedge clk); #2 start_i = 1'b0;
        chk("R8 done cleared by start", done_o, 0);
        chk("R8 busy after start", busy_o, 1);
        wait_done(1'b0);

        // R7 start mid-run ignored
        run_rec(15, 1'b1);
        #1;
        chk("R7 pulse count with mid-run start", falls_pre, 9);
        chk("R7 still fails with mid-run start", fail_o, 1);

        // R9 stretched high phase
        stretch_arm = 1'b1;
        run_rec(15, 1'b0);
        stretch_arm = 1'b0;
        #1;
        chk("R9 stretched high phase lengthened", int'(hi4 >= 12), 1);
        chk("R9 pulse count with stretch", falls_pre, 9);
        chk("R9 done after stretch", done_o, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule